// File: doc/BRIEF.md
# Multi-cycle integer divider with condition flags

This block divides integers one quotient bit per clock for a processor core whose registers are `W` bits wide (32 by default). It offers three operand shapes. The short form divides a full register by the lower half of the divisor and packs a half-width remainder and a half-width quotient into one register. The single form divides one register by one register. The double form divides a dividend built from two registers. Each shape can be unsigned or signed. A signed quotient truncates toward zero, and the remainder keeps the sign of the dividend.

The core pulses `start` while the unit is idle, with operands and controls held steady during that cycle. Later the unit pulses `done` for one cycle. In that cycle it presents the register values to write, together with per-register write strobes. Alternatively it flags a divide-by-zero trap in place of any result. The condition flags are kept in the unit and change only as each result completes. When a quotient overflows, the negative flag and the destination keep their old values.

Top module: `idiv_unit`

## Requirements
- R1: `flag_c` reads 0 after every completion, including a zero-divisor trap and a quotient overflow.
- R2: A zero effective divisor means `divisor[W/2-1:0]` in the short form and the whole `divisor` in the other forms. For such a divisor, `done` and `dz_trap` rise on the edge that accepts `start`, neither write strobe is raised, and `flag_n`, `flag_z` and `flag_v` keep their values.
- R3: In the short form (`mode`=2'b00) the quotient overflows when the unsigned quotient exceeds 2^(W/2)-1. Signed, it overflows when the quotient falls outside [-2^(W/2-1), 2^(W/2-1)-1].
- R4: On quotient overflow, `flag_v` is set, `flag_z` is cleared, `flag_n` is unchanged, and neither `wr_q` nor `wr_r` is raised.
- R5: In the short form without overflow, `wr_q` is raised with `q_val` = {remainder[W/2-1:0], quotient[W/2-1:0]} and `wr_r` stays low. `flag_n` is quotient bit W/2-1, `flag_z` is set when the half-width quotient is zero, and `flag_v` is cleared.
- R6: In the double form (`mode`=2'b10) the dividend is {`op_hi`,`op_lo`}. The quotient overflows when it does not fit in W bits, read as unsigned or as signed two's complement according to `is_signed`.
- R7: In the single form (`mode`=2'b01 or 2'b11) the dividend is `op_lo`, and a signed quotient of 2^(W-1) overflows. In both single and double forms without overflow, `wr_q` carries the quotient on `q_val`. `wr_r` carries the remainder on `r_val` only when `same_reg` is 0. `flag_n` is quotient bit W-1, `flag_z` is set for a zero quotient, and `flag_v` is cleared.
- R8: Signed division truncates toward zero, and the nonzero remainder has the sign of the dividend.
- R9: A non-trapping operation raises `done` on the (2W+1)-th rising edge after the accepting edge. `busy` is high from the accepting edge until `done`. `done` lasts one cycle. A `start` seen while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `dz_trap`, the write strobes and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a division; taken only while idle |
| is_signed | input | 1 | 1 selects two's complement operands |
| mode | input | 2 | 00 short form, 01/11 single form, 10 double form |
| same_reg | input | 1 | Quotient and remainder name the same register |
| op_hi | input | W | Upper dividend register (double form only) |
| op_lo | input | W | Dividend register, or lower half of a double dividend |
| divisor | input | W | Divisor (lower half used by the short form) |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| dz_trap | output | 1 | With `done`: divide-by-zero trap, no result |
| wr_q | output | 1 | With `done`: write `q_val` to the quotient register |
| q_val | output | W | Quotient, or packed remainder/quotient in the short form |
| wr_r | output | 1 | With `done`: write `r_val` to the remainder register |
| r_val | output | W | Remainder (single and double forms) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Some rules are checked by the assertions on every cycle. `done` is a single-cycle pulse and never coincides with `busy`. A trap writes nothing. An overflow writes nothing, clears zero and keeps the negative flag. The remainder register of the datapath is always below the divisor when results are taken. The remainder strobe never appears without the quotient strobe. Only the bench's scenarios can show that the numeric results are right for each form and signedness. The same holds for where the overflow boundaries fall, the packing of the short result, the `same_reg` choice, the exact latency and the ignoring of a `start` during a run. The bench does this with sweeps on an 8-bit configuration, against results it computes with native integer division.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  localparam logic [1:0] DM_WORD = 2'b00;
  localparam logic [1:0] DM_LONG = 2'b01;
  localparam logic [1:0] DM_WIDE = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} dstate_e;
endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: selects the dividend and divisor per form and
// turns them into magnitudes plus result signs.
module idiv_prep import idiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic [1:0]     mode,
  input  logic           sgn,
  input  logic [W-1:0]   op_hi,
  input  logic [W-1:0]   op_lo,
  input  logic [W-1:0]   dsr,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   dsr_mag,
  output logic           q_neg,
  output logic           r_neg,
  output logic           dsr_zero
);
  localparam int H = W / 2;

  logic [2*W-1:0] dvd;
  logic [W-1:0]   d;
  logic           dvd_neg, d_neg;

  always_comb begin
    if (mode == DM_WIDE) dvd = {op_hi, op_lo};
    else if (sgn)        dvd = {{W{op_lo[W-1]}}, op_lo};
    else                 dvd = {{W{1'b0}}, op_lo};

    if (mode == DM_WORD) d = sgn ? {{H{dsr[H-1]}}, dsr[H-1:0]} : {{H{1'b0}}, dsr[H-1:0]};
    else                 d = dsr;

    dvd_neg  = sgn & dvd[2*W-1];
    d_neg    = sgn & d[W-1];
    dvd_mag  = dvd_neg ? -dvd : dvd;
    dsr_mag  = d_neg ? -d : d;
    q_neg    = dvd_neg ^ d_neg;
    r_neg    = dvd_neg;
    dsr_zero = (d == '0);
  end
endmodule

// File: rtl/idiv_core.sv
// Radix-2 restoring iteration on magnitudes: one quotient bit per step.
module idiv_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dvd_mag,
  input  logic [W-1:0]   dsr_mag,
  output logic [2*W-1:0] quo_mag,
  output logic [W-1:0]   rem_mag,
  output logic [W-1:0]   dsr_q
);
  logic [W:0]   shifted;
  logic         ge;
  logic [W-1:0] rem_nx;

  function automatic logic [W:0] sub_trial(input logic [W:0] a, input logic [W-1:0] b);
    return a - {1'b0, b};
  endfunction

  always_comb begin
    shifted = {rem_mag, quo_mag[2*W-1]};
    ge      = (shifted >= {1'b0, dsr_q});
    rem_nx  = ge ? sub_trial(shifted, dsr_q)[W-1:0] : shifted[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_mag <= '0;
      rem_mag <= '0;
      dsr_q   <= '0;
    end else if (load) begin
      quo_mag <= dvd_mag;
      rem_mag <= '0;
      dsr_q   <= dsr_mag;
    end else if (step) begin
      quo_mag <= {quo_mag[2*W-2:0], ge};
      rem_mag <= rem_nx;
    end
  end
endmodule

// File: rtl/idiv_post.sv
// Result shaping: sign restore, overflow test, packing and flag values.
module idiv_post import idiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] quo_mag,
  input  logic [W-1:0]   rem_mag,
  input  logic           q_neg,
  input  logic           r_neg,
  input  logic           sgn,
  input  logic [1:0]     mode,
  output logic           ovf,
  output logic [W-1:0]   res_q,
  output logic [W-1:0]   res_r,
  output logic           res_n,
  output logic           res_z
);
  localparam int H = W / 2;
  localparam logic [2*W-1:0] ONE = 1;

  logic [W-1:0] qs;

  function automatic logic quo_ovf(input logic [2*W-1:0] mag, input logic neg,
                                   input logic s, input int rw);
    if (!s)       return (mag >> rw) != '0;
    else if (neg) return mag > (ONE << (rw - 1));
    else          return mag >= (ONE << (rw - 1));
  endfunction

  always_comb begin
    qs    = q_neg ? -quo_mag[W-1:0] : quo_mag[W-1:0];
    res_r = r_neg ? -rem_mag : rem_mag;
    if (mode == DM_WORD) begin
      ovf   = quo_ovf(quo_mag, q_neg, sgn, H);
      res_q = {res_r[H-1:0], qs[H-1:0]};
      res_n = qs[H-1];
      res_z = (qs[H-1:0] == '0);
    end else begin
      ovf   = quo_ovf(quo_mag, q_neg, sgn, W);
      res_q = qs;
      res_n = qs[W-1];
      res_z = (qs == '0);
    end
  end
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit import idiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [1:0]   mode,
  input  logic         same_reg,
  input  logic [W-1:0] op_hi,
  input  logic [W-1:0] op_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         dz_trap,
  output logic         wr_q,
  output logic [W-1:0] q_val,
  output logic         wr_r,
  output logic [W-1:0] r_val,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c
);
  localparam int ITER = 2 * W;
  localparam int CW   = $clog2(ITER + 1);

  dstate_e        st;
  logic [CW-1:0]  cnt;
  logic [1:0]     mode_l;
  logic           sgn_l, same_l, qneg_l, rneg_l;

  logic [2*W-1:0] dvd_mag, quo_mag;
  logic [W-1:0]   dsr_mag, rem_mag, dsr_q, res_q, res_r;
  logic           q_neg, r_neg, dsr_zero, ovf, res_n, res_z;

  // named internal events
  logic accept, dz_hit, stepping, finish;
  assign accept   = (st == S_IDLE) && start && !dsr_zero;
  assign dz_hit   = (st == S_IDLE) && start && dsr_zero;
  assign stepping = (st == S_RUN);
  assign finish   = (st == S_FIN);
  assign busy     = (st != S_IDLE);

  idiv_prep #(.W(W)) u_prep (
    .mode(mode), .sgn(is_signed), .op_hi(op_hi), .op_lo(op_lo), .dsr(divisor),
    .dvd_mag(dvd_mag), .dsr_mag(dsr_mag), .q_neg(q_neg), .r_neg(r_neg),
    .dsr_zero(dsr_zero));

  idiv_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(stepping),
    .dvd_mag(dvd_mag), .dsr_mag(dsr_mag),
    .quo_mag(quo_mag), .rem_mag(rem_mag), .dsr_q(dsr_q));

  idiv_post #(.W(W)) u_post (
    .quo_mag(quo_mag), .rem_mag(rem_mag), .q_neg(qneg_l), .r_neg(rneg_l),
    .sgn(sgn_l), .mode(mode_l), .ovf(ovf), .res_q(res_q), .res_r(res_r),
    .res_n(res_n), .res_z(res_z));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;
      mode_l <= DM_WORD;  sgn_l <= 1'b0;  same_l <= 1'b0;
      qneg_l <= 1'b0;  rneg_l <= 1'b0;
      done <= 1'b0;  dz_trap <= 1'b0;  wr_q <= 1'b0;  wr_r <= 1'b0;
      q_val <= '0;  r_val <= '0;
      flag_n <= 1'b0;  flag_z <= 1'b0;  flag_v <= 1'b0;  flag_c <= 1'b0;
    end else begin
      done <= 1'b0;  dz_trap <= 1'b0;  wr_q <= 1'b0;  wr_r <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (dz_hit) begin
            done <= 1'b1;  dz_trap <= 1'b1;  flag_c <= 1'b0;
          end else if (accept) begin
            mode_l <= mode;  sgn_l <= is_signed;  same_l <= same_reg;
            qneg_l <= q_neg;  rneg_l <= r_neg;
            cnt <= '0;
            st <= S_RUN;
          end
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ITER - 1)) st <= S_FIN;
        end
        S_FIN: begin
          st <= S_IDLE;
          done <= 1'b1;
          flag_c <= 1'b0;
          if (ovf) begin
            flag_v <= 1'b1;  flag_z <= 1'b0;
          end else begin
            flag_v <= 1'b0;  flag_n <= res_n;  flag_z <= res_z;
            wr_q  <= 1'b1;
            wr_r  <= (mode_l != DM_WORD) && !same_l;
            q_val <= res_q;
            r_val <= res_r;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  dz_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap |-> (done && !wr_q && !wr_r));
  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap && flag_v) |-> (!flag_z && !wr_q && !wr_r && flag_n == $past(flag_n)));
  // R7
  rem_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_r |-> wr_q);
  // R8
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (rem_mag < dsr_q));
endmodule

// File: tb/idiv_unit_bench.sv
module idiv_unit_bench;
  localparam int W = 8;
  localparam int H = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_signed = 1'b0, same_reg = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] op_hi = '0, op_lo = '0, divisor = '0;
  logic busy, done, dz_trap, wr_q, wr_r, flag_n, flag_z, flag_v, flag_c;
  logic [W-1:0] q_val, r_val;

  int checks = 0, fails = 0, edges = 0;
  logic en = 1'b0, ez = 1'b0, ev = 1'b0;

  always #4 clk = ~clk;

  idiv_unit #(.W(W)) u_idiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed), .mode(mode),
    .same_reg(same_reg), .op_hi(op_hi), .op_lo(op_lo), .divisor(divisor),
    .busy(busy), .done(done), .dz_trap(dz_trap), .wr_q(wr_q), .q_val(q_val),
    .wr_r(wr_r), .r_val(r_val), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      edges++;
      if (edges > 190000) begin
        fails++;
        $display("FAIL watchdog: actual=%0d expected<190000 cycles", edges);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  task automatic do_op(input logic [1:0] m, input logic s, input logic same,
                       input logic [W-1:0] hi, input logic [W-1:0] lo,
                       input logic [W-1:0] d, input bit poke);
    longint dvd, dv, q, r, lim, msk;
    bit dz, ovf;
    int cyc;
    string rq;
    logic eq_wr_r;
    logic [W-1:0] eq, er;
    if (m == 2'b10) dvd = s ? longint'($signed({hi, lo})) : longint'({hi, lo});
    else            dvd = s ? longint'($signed(lo)) : longint'(lo);
    if (m == 2'b00) dv = s ? longint'($signed(d[H-1:0])) : longint'(d[H-1:0]);
    else            dv = s ? longint'($signed(d)) : longint'(d);
    dz = (dv == 0);
    q = dz ? 0 : dvd / dv;
    r = dz ? 0 : dvd % dv;
    lim = (m == 2'b00) ? H : W;
    msk = (longint'(1) << lim) - 1;
    ovf = s ? (q < -(longint'(1) << (lim - 1)) || q >= (longint'(1) << (lim - 1)))
            : (q > msk);
    rq = dz ? "R2" : (m == 2'b00) ? (ovf ? "R3" : (s ? "R8" : "R5"))
                   : (m == 2'b10) ? (ovf ? "R6" : (s ? "R8" : "R6"))
                   : (s ? "R8" : "R7");

    @(negedge clk);
    mode = m; is_signed = s; same_reg = same; op_hi = hi; op_lo = lo; divisor = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 64) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        chk(busy === 1'b1, "R9", "busy during run", busy, 1);
        start = 1'b1; op_lo = ~op_lo; divisor = divisor + 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;

    chk(cyc == (dz ? 1 : 2 * W + 2), "R9", "done latency", cyc, dz ? 1 : 2 * W + 2);
    chk(dz_trap === dz, "R2", "dz_trap", dz_trap, dz);
    chk(flag_c === 1'b0, "R1", "carry flag", flag_c, 0);
    if (!dz) begin
      if (ovf) begin
        ev = 1'b1; ez = 1'b0;
        chk(wr_q === 1'b0 && wr_r === 1'b0, "R4", "no write on overflow", {wr_q, wr_r}, 0);
      end else begin
        ev = 1'b0;
        en = q[lim - 1];
        ez = ((q & msk) == 0);
        eq_wr_r = (m != 2'b00) && !same;
        if (m == 2'b00) eq = {r[H-1:0], q[H-1:0]};
        else            eq = q[W-1:0];
        er = r[W-1:0];
        chk(wr_q === 1'b1, rq, "wr_q", wr_q, 1);
        chk(wr_r === eq_wr_r, (m == 2'b00) ? "R5" : "R7", "wr_r", wr_r, eq_wr_r);
        chk(q_val === eq, rq, "q_val", q_val, eq);
        if (eq_wr_r) chk(r_val === er, rq, "r_val", r_val, er);
      end
    end else begin
      chk(wr_q === 1'b0 && wr_r === 1'b0, "R2", "no write on trap", {wr_q, wr_r}, 0);
    end
    chk(flag_v === ev, ovf ? "R4" : rq, "flag_v", flag_v, ev);
    chk(flag_z === ez, ovf ? "R4" : rq, "flag_z", flag_z, ez);
    chk(flag_n === en, ovf ? "R4" : rq, "flag_n", flag_n, en);
  endtask

  initial begin
    logic [31:0] lcg;
    lcg = 32'h1234_5677;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, done, dz_trap, wr_q, wr_r} === 5'b0, "R10", "control outputs", {busy, done, dz_trap, wr_q, wr_r}, 0);
    chk({flag_n, flag_z, flag_v, flag_c} === 4'b0, "R10", "flags", {flag_n, flag_z, flag_v, flag_c}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // short form sweep (R3, R5, R8, R2)
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 16; b++)
        for (int s = 0; s < 2; s++)
          do_op(2'b00, s[0], a[0], 8'h00, a[7:0], {4'hA, b[3:0]}, 1'b0);

    // single form sweep, both encodings (R7, R8)
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 7)
        for (int s = 0; s < 2; s++)
          do_op((b % 2 == 0) ? 2'b01 : 2'b11, s[0], a[1], 8'h5A, a[7:0], b[7:0], 1'b0);
    // R7 signed minimum by minus one overflows
    do_op(2'b01, 1'b1, 1'b0, 8'h00, 8'h80, 8'hFF, 1'b0);
    do_op(2'b01, 1'b0, 1'b1, 8'h00, 8'hFF, 8'h01, 1'b0);

    // double form (R6, R8)
    for (int k = 0; k < 700; k++) begin
      logic [W-1:0] hi, lo, d;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      lo = lcg[23:16];
      d  = lcg[31:24];
      case (k % 4)
        0: hi = lcg[15:8];
        1: hi = {5'b0, lcg[10:8]};
        2: hi = lo[7] ? 8'hFF : 8'h00;
        default: hi = {8{lcg[9]}} ^ {6'b0, lcg[11:10]};
      endcase
      do_op(2'b10, k[0], k[1], hi, lo, d, 1'b0);
    end
    do_op(2'b10, 1'b1, 1'b0, 8'hC0, 8'h00, 8'h80, 1'b0);
    do_op(2'b10, 1'b1, 1'b0, 8'h40, 8'h00, 8'h80, 1'b0);
    do_op(2'b10, 1'b0, 1'b0, 8'h7F, 8'hFF, 8'h80, 1'b0);
    do_op(2'b10, 1'b0, 1'b1, 8'h12, 8'h34, 8'h00, 1'b0);

    // R9 start during a run is ignored
    do_op(2'b01, 1'b1, 1'b0, 8'h00, 8'h9B, 8'h07, 1'b1);
    do_op(2'b00, 1'b0, 1'b0, 8'h00, 8'hC8, 8'h0B, 1'b1);
    do_op(2'b10, 1'b0, 1'b0, 8'h03, 8'h21, 8'h29, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule